// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of hardware timers and the interrupt fabric. Each cycle a timer may raise a one-cycle fire pulse. The router turns each pulse into one of three results:

- a pulse on an interrupt-controller pin;
- a held (level) assertion on such a pin;
- an interrupt message carrying a vector and a destination.

Which result applies depends on the timer's own configuration word and on one global legacy-route bit. The router keeps a level status bit for every timer whose pin is held. Software clears these bits through clear requests, and the router then releases the pin.

Each timer's configuration word is written through a small write port: one timer index and one word per cycle. The router checks the programmed pin against a per-timer allowed-pin mask before storing the word. A write that would leave a held level interrupt stuck releases that pin straight away.

All outputs are registered, and the block issues at most one command per cycle. When several events compete, the order is fixed:

1. a release caused by a configuration write;
2. pending clear requests, lowest timer first;
3. pending fires, lowest timer first.

Events that lose arbitration wait in internal pending bits.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset the command output is none (code 0), all status bits are 0, and no message is issued. Whenever no pin command is issued, the pin index reads 0. Whenever no message is issued, the vector and destination read 0. The command codes are: 0 none, 1 assert, 2 deassert, 3 pulse.
- R2: With the legacy-route bit set, an enabled fire of timer 0 pulses pin 2 and one of timer 1 pulses pin 8. This holds whatever the type, route and message-enable settings of those timers are.
- R3: A timer delivers by message only when it is message-capable (a per-timer parameter bit) and its message-enable bit (config bit 2) is set. The message carries that timer's vector and destination inputs. A destination of 0xFF also raises the broadcast flag.
- R4: Otherwise the pin is the route field, config bits 7:3. A route of 0 means the timer is not connected, and its fires produce no command.
- R5: On a config write, a nonzero route whose bit is clear in that timer's 32-bit allowed-pin mask is stored as 0.
- R6: A fire is ignored when the timer's interrupt-enable bit (config bit 0) is 0. It is also ignored while the timer's status bit is already set.
- R7: A timer whose type bit (config bit 1) is 0 issues a pulse on its pin. A timer with the type bit set to 1 sets its status bit and issues an assert on its pin. The command appears one cycle after the fire.
- R8: A clear request for a timer whose status bit is set issues a deassert on the pin that was asserted and clears the bit. A clear request for a timer whose status bit is clear has no effect.
- R9: When a timer's status bit is set, a config write to that timer releases the pin if the new word leaves any one of these true:
  - the interrupt is disabled;
  - delivery is by message;
  - the type is edge;
  - the pin differs from the held one.

  A release issues a deassert of the held pin one cycle after the write and clears the status bit. Any other write keeps the bit.
- R10: Only one command (pin or message) is issued per cycle. When several clear requests, or several fires, are pending at once, they are served one per cycle from the lowest timer index upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_en | input | 1 | Global legacy-route bit |
| fire | input | NUM_TMR | One-cycle fire pulse per timer |
| clr_req | input | NUM_TMR | Status clear request per timer |
| cfg_we | input | 1 | Config write strobe |
| cfg_idx | input | IDX_W | Timer index of the config write |
| cfg_wdata | input | 8 | Config word {route[4:0], msg_en, level, ien} |
| msg_vec_i | input | NUM_TMR*8 | Per-timer message vector |
| msg_dest_i | input | NUM_TMR*8 | Per-timer message destination |
| pin_cmd | output | 2 | Pin command code |
| pin_num | output | 5 | Pin index of the command |
| msg_valid | output | 1 | Message issued this cycle |
| msg_vec | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_bcast | output | 1 | Message goes to all active targets |
| status | output | NUM_TMR | Level status bits |

## Verification
Every timer index is driven through every combination of the enable, type and message-enable bits, under both settings of the legacy bit. Each combination is tried with three routes: an unconnected route, an allowed pin and a disallowed pin. This sweep tells apart the precedence of legacy over message over pin delivery, and it includes a timer that is not message-capable. A repeated fire on a held level timer separates the ignore rule from a fresh assert.

Directed sequences cover the following:
- each of the four release conditions of a config write, plus a write that must keep the status bit;
- single and redundant clear requests;
- three simultaneous fires and three simultaneous clears, which show the lowest-first order one cycle at a time.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int PIN_W  = 5;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MASK_W = 1 << PIN_W;
  localparam int CFG_W  = PIN_W + 3;

  typedef enum logic [1:0] {
    PC_NONE     = 2'd0,
    PC_ASSERT   = 2'd1,
    PC_DEASSERT = 2'd2,
    PC_PULSE    = 2'd3
  } pin_cmd_e;

  typedef struct packed {
    logic [PIN_W-1:0] route;
    logic             msg_en;
    logic             level;
    logic             ien;
  } tmr_cfg_t;

  localparam logic [PIN_W-1:0]  LEG_PIN_T0 = PIN_W'(2);
  localparam logic [PIN_W-1:0]  LEG_PIN_T1 = PIN_W'(8);
  localparam logic [DEST_W-1:0] DEST_ALL   = {DEST_W{1'b1}};
endpackage

// File: rtl/irqr_route_decode.sv
module irqr_route_decode
  import irqr_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] tmr_idx,
  input  logic             legacy_en,
  input  logic             msg_cap,
  input  tmr_cfg_t         cfg,
  output logic             use_msg,
  output logic             use_edge,
  output logic [PIN_W-1:0] pin
);
  logic legacy_hit;
  assign legacy_hit = legacy_en &&
                      ((tmr_idx == IDX_W'(0)) || (tmr_idx == IDX_W'(1)));

  always_comb begin
    if (legacy_hit) begin
      use_msg  = 1'b0;
      use_edge = 1'b1;
      pin      = tmr_idx[0] ? LEG_PIN_T1 : LEG_PIN_T0;
    end else begin
      use_msg  = msg_cap & cfg.msg_en;
      use_edge = ~cfg.level;
      pin      = cfg.route;
    end
  end
endmodule

// File: rtl/irqr_first_set.sv
module irqr_first_set #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import irqr_pkg::*;
#(
  parameter  int                         NUM_TMR    = 4,
  parameter  logic [NUM_TMR-1:0]         MSG_CAP    = '1,
  parameter  logic [NUM_TMR*MASK_W-1:0]  ALLOW_MASK = {NUM_TMR{32'h00FF_0000}},
  localparam int                         IDX_W      = $clog2(NUM_TMR)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      legacy_en,
  input  logic [NUM_TMR-1:0]        fire,
  input  logic [NUM_TMR-1:0]        clr_req,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic [CFG_W-1:0]          cfg_wdata,
  input  logic [NUM_TMR*VEC_W-1:0]  msg_vec_i,
  input  logic [NUM_TMR*DEST_W-1:0] msg_dest_i,
  output logic [1:0]                pin_cmd,
  output logic [PIN_W-1:0]          pin_num,
  output logic                      msg_valid,
  output logic [VEC_W-1:0]          msg_vec,
  output logic [DEST_W-1:0]         msg_dest,
  output logic                      msg_bcast,
  output logic [NUM_TMR-1:0]        status
);
  tmr_cfg_t           cfg_q   [NUM_TMR];
  logic [PIN_W-1:0]   held_q  [NUM_TMR];
  logic [MASK_W-1:0]  allow_of[NUM_TMR];
  logic [PIN_W-1:0]   dec_pin [NUM_TMR];
  logic [NUM_TMR-1:0] dec_msg, dec_edge;
  logic [NUM_TMR-1:0] status_q, fire_pend, clr_pend;

  // Per-timer decode of the current delivery path.
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign allow_of[g] = ALLOW_MASK[g*MASK_W +: MASK_W];
    irqr_route_decode #(.IDX_W(IDX_W)) u_dec (
      .tmr_idx  (IDX_W'(g)),
      .legacy_en(legacy_en),
      .msg_cap  (MSG_CAP[g]),
      .cfg      (cfg_q[g]),
      .use_msg  (dec_msg[g]),
      .use_edge (dec_edge[g]),
      .pin      (dec_pin[g])
    );
  end

  // Write path: validate the route, then decode the new word.
  tmr_cfg_t         wr_raw, wr_cfg;
  logic             wr_msg, wr_edge, drop;
  logic [PIN_W-1:0] wr_pin;

  assign wr_raw = tmr_cfg_t'(cfg_wdata);
  always_comb begin
    wr_cfg = wr_raw;
    if (wr_raw.route != '0 && !allow_of[cfg_idx][wr_raw.route]) wr_cfg.route = '0;
  end

  irqr_route_decode #(.IDX_W(IDX_W)) u_wr_dec (
    .tmr_idx  (cfg_idx),
    .legacy_en(legacy_en),
    .msg_cap  (MSG_CAP[cfg_idx]),
    .cfg      (wr_cfg),
    .use_msg  (wr_msg),
    .use_edge (wr_edge),
    .pin      (wr_pin)
  );

  assign drop = cfg_we && status_q[cfg_idx] &&
                (!wr_cfg.ien || wr_msg || wr_edge || (wr_pin != held_q[cfg_idx]));

  // Arbitration among pending clears and fires.
  logic [NUM_TMR-1:0] eff_clr, eff_fire;
  logic               clr_any, fire_any;
  logic [IDX_W-1:0]   clr_sel, fire_sel;

  assign eff_clr  = (clr_pend | clr_req) & status_q;
  assign eff_fire = fire_pend | fire;

  irqr_first_set #(.N(NUM_TMR)) u_clr_pick  (.req(eff_clr),  .any(clr_any),  .idx(clr_sel));
  irqr_first_set #(.N(NUM_TMR)) u_fire_pick (.req(eff_fire), .any(fire_any), .idx(fire_sel));

  pin_cmd_e           cmd_d;
  logic [PIN_W-1:0]   pin_d;
  logic               msg_d;
  logic [VEC_W-1:0]   vec_d;
  logic [DEST_W-1:0]  dest_d;
  logic [NUM_TMR-1:0] clr_mask, set_mask, fire_done;

  always_comb begin
    cmd_d     = PC_NONE;
    pin_d     = '0;
    msg_d     = 1'b0;
    vec_d     = '0;
    dest_d    = '0;
    clr_mask  = '0;
    set_mask  = '0;
    fire_done = '0;
    if (drop) begin
      cmd_d             = PC_DEASSERT;
      pin_d             = held_q[cfg_idx];
      clr_mask[cfg_idx] = 1'b1;
    end else if (clr_any) begin
      cmd_d             = PC_DEASSERT;
      pin_d             = held_q[clr_sel];
      clr_mask[clr_sel] = 1'b1;
    end else if (fire_any) begin
      fire_done[fire_sel] = 1'b1;
      if (cfg_q[fire_sel].ien && !status_q[fire_sel]) begin
        if (dec_msg[fire_sel]) begin
          msg_d  = 1'b1;
          vec_d  = msg_vec_i[fire_sel*VEC_W +: VEC_W];
          dest_d = msg_dest_i[fire_sel*DEST_W +: DEST_W];
        end else if (dec_pin[fire_sel] != '0) begin
          pin_d = dec_pin[fire_sel];
          if (dec_edge[fire_sel]) begin
            cmd_d = PC_PULSE;
          end else begin
            cmd_d              = PC_ASSERT;
            set_mask[fire_sel] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      fire_pend <= '0;
      clr_pend  <= '0;
      pin_cmd   <= PC_NONE;
      pin_num   <= '0;
      msg_valid <= 1'b0;
      msg_vec   <= '0;
      msg_dest  <= '0;
      msg_bcast <= 1'b0;
      for (int i = 0; i < NUM_TMR; i++) begin
        cfg_q[i]  <= '0;
        held_q[i] <= '0;
      end
    end else begin
      status_q  <= (status_q & ~clr_mask) | set_mask;
      fire_pend <= eff_fire & ~fire_done;
      clr_pend  <= eff_clr & ~clr_mask;
      pin_cmd   <= cmd_d;
      pin_num   <= pin_d;
      msg_valid <= msg_d;
      msg_vec   <= vec_d;
      msg_dest  <= dest_d;
      msg_bcast <= msg_d && (dest_d == DEST_ALL);
      if (|set_mask) held_q[fire_sel] <= pin_d;
      if (cfg_we)    cfg_q[cfg_idx]   <= wr_cfg;
    end
  end

  assign status = status_q;

  // Checks on the registered outputs.
  assert_cmd_has_pin_R4: assert property (@(posedge clk) disable iff (rst)
    (pin_cmd != PC_NONE) |-> (pin_num != '0));
  assert_one_action_R10: assert property (@(posedge clk) disable iff (rst)
    !(msg_valid && pin_cmd != PC_NONE));
  assert_one_status_step_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(status_q ^ $past(status_q)) <= 1);
  assert_rise_asserts_R7: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & ~$past(status_q))) |-> (pin_cmd == PC_ASSERT));
  assert_fall_deasserts_R8: assert property (@(posedge clk) disable iff (rst)
    (|(~status_q & $past(status_q))) |-> (pin_cmd == PC_DEASSERT));
  assert_bcast_needs_msg_R3: assert property (@(posedge clk) disable iff (rst)
    msg_bcast |-> msg_valid);
endmodule

// File: tb/tmr_irq_router_tb.sv
module tmr_irq_router_tb;
  localparam int N = 4;

  logic         clk = 1'b0, rst = 1'b1, legacy_en = 1'b0, cfg_we = 1'b0;
  logic [N-1:0] fire = '0, clr_req = '0;
  logic [1:0]   cfg_idx = '0;
  logic [7:0]   cfg_wdata = '0;
  logic [31:0]  msg_vec_i  = 32'h4342_4140;
  logic [31:0]  msg_dest_i = 32'h13FF_1110;
  logic [1:0]   pin_cmd;
  logic [4:0]   pin_num;
  logic         msg_valid, msg_bcast;
  logic [7:0]   msg_vec, msg_dest;
  logic [N-1:0] status;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  tmr_irq_router #(
    .NUM_TMR(N), .MSG_CAP(4'b0111), .ALLOW_MASK({4{32'h00FF_0000}})
  ) u_dut (
    .clk, .rst, .legacy_en, .fire, .clr_req, .cfg_we, .cfg_idx, .cfg_wdata,
    .msg_vec_i, .msg_dest_i, .pin_cmd, .pin_num, .msg_valid, .msg_vec,
    .msg_dest, .msg_bcast, .status
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; legacy_en = 1'b0; fire = '0; clr_req = '0; cfg_we = 1'b0;
    repeat (2) tick();
    rst = 1'b0;
  endtask

  task automatic wr(input int t, input logic [7:0] v);
    cfg_we = 1'b1; cfg_idx = 2'(t); cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic firep(input logic [N-1:0] m);
    fire = m;
    tick();
    fire = '0;
  endtask

  function automatic logic [7:0] mk(input logic [4:0] r, input logic me,
                                    input logic lv, input logic ie);
    return {r, me, lv, ie};
  endfunction

  task automatic check(input string tag, input logic [1:0] ecmd, input logic [4:0] epin,
                       input logic emsg, input logic [7:0] evec, input logic [7:0] edest,
                       input logic ebc, input logic [N-1:0] est);
    checks++;
    if (pin_cmd !== ecmd || pin_num !== epin || msg_valid !== emsg || msg_vec !== evec ||
        msg_dest !== edest || msg_bcast !== ebc || status !== est) begin
      fails++;
      $display("FAIL %s: got cmd=%0d pin=%0d msg=%0b vec=%h dest=%h bc=%0b st=%b; expected cmd=%0d pin=%0d msg=%0b vec=%h dest=%h bc=%0b st=%b",
               tag, pin_cmd, pin_num, msg_valid, msg_vec, msg_dest, msg_bcast, status,
               ecmd, epin, emsg, evec, edest, ebc, est);
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset", 2'd0, 5'd0, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0);

    // Sweep: timer x mode bits x legacy x route {0, allowed 17, disallowed 5}
    for (int t = 0; t < N; t++)
      for (int c = 0; c < 8; c++)
        for (int lg = 0; lg < 2; lg++)
          for (int ri = 0; ri < 3; ri++) begin
            logic [4:0] rt;
            logic [1:0] ecmd;
            logic [4:0] epin;
            logic       emsg, ebc;
            logic [7:0] evec, edest;
            logic [N-1:0] est;
            string tag;
            rt = (ri == 0) ? 5'd0 : (ri == 1) ? 5'd17 : 5'd5;
            ecmd = 2'd0; epin = '0; emsg = 1'b0; ebc = 1'b0; evec = '0; edest = '0; est = '0;
            do_reset();
            legacy_en = lg[0];
            wr(t, mk(rt, c[2], c[1], c[0]));
            firep(4'(1 << t));
            if (!c[0]) tag = "R6 disabled";
            else if (lg == 1 && t < 2) begin
              tag = "R2 legacy"; ecmd = 2'd3; epin = (t == 1) ? 5'd8 : 5'd2;
            end else if (c[2] && t != 3) begin
              tag = "R3 message"; emsg = 1'b1; evec = 8'(8'h40 + t);
              edest = msg_dest_i[t*8 +: 8]; ebc = (edest == 8'hFF);
            end else if (rt == 5'd0) tag = "R4 unrouted";
            else if (rt == 5'd5) tag = "R5 invalid pin";
            else if (c[1]) begin
              tag = "R7 level"; ecmd = 2'd1; epin = 5'd17; est = 4'(1 << t);
            end else begin
              tag = "R7 edge"; ecmd = 2'd3; epin = 5'd17;
            end
            check(tag, ecmd, epin, emsg, evec, edest, ebc, est);
            if (est != '0) begin
              firep(4'(1 << t));
              check("R6 already held", 2'd0, 5'd0, 1'b0, 8'h0, 8'h0, 1'b0, est);
            end
          end

    // R8 clear requests
    do_reset();
    wr(1, mk(5'd20, 1'b0, 1'b1, 1'b1));
    firep(4'b0010);
    check("R8 setup", 2'd1, 5'd20, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0010);
    clr_req = 4'b0010; tick(); clr_req = '0;
    check("R8 clear", 2'd2, 5'd20, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0000);
    clr_req = 4'b0010; tick(); clr_req = '0;
    check("R8 redundant clear", 2'd0, 5'd0, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0000);

    // R9 release on config change: disable, message, edge, pin change
    for (int k = 0; k < 4; k++) begin
      logic [7:0] nv;
      do_reset();
      wr(2, mk(5'd17, 1'b0, 1'b1, 1'b1));
      firep(4'b0100);
      check("R9 setup", 2'd1, 5'd17, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0100);
      case (k)
        0:       nv = mk(5'd17, 1'b0, 1'b1, 1'b0);
        1:       nv = mk(5'd17, 1'b1, 1'b1, 1'b1);
        2:       nv = mk(5'd17, 1'b0, 1'b0, 1'b1);
        default: nv = mk(5'd18, 1'b0, 1'b1, 1'b1);
      endcase
      wr(2, nv);
      check("R9 release", 2'd2, 5'd17, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0000);
    end
    do_reset();
    wr(2, mk(5'd17, 1'b0, 1'b1, 1'b1));
    firep(4'b0100);
    wr(2, mk(5'd17, 1'b0, 1'b1, 1'b1));
    check("R9 keep on same word", 2'd0, 5'd0, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0100);
    do_reset();
    wr(3, mk(5'd19, 1'b0, 1'b1, 1'b1));
    firep(4'b1000);
    wr(3, mk(5'd19, 1'b1, 1'b1, 1'b1));
    check("R9 keep, not message-capable", 2'd0, 5'd0, 1'b0, 8'h0, 8'h0, 1'b0, 4'b1000);

    // R10 ordering
    do_reset();
    wr(0, mk(5'd16, 1'b0, 1'b1, 1'b1));
    wr(1, mk(5'd17, 1'b0, 1'b1, 1'b1));
    wr(2, mk(5'd18, 1'b0, 1'b1, 1'b1));
    firep(4'b0111);
    check("R10 fire order 1", 2'd1, 5'd16, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0001);
    tick();
    check("R10 fire order 2", 2'd1, 5'd17, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0011);
    tick();
    check("R10 fire order 3", 2'd1, 5'd18, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0111);
    clr_req = 4'b0111; tick(); clr_req = '0;
    check("R10 clear order 1", 2'd2, 5'd16, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0110);
    tick();
    check("R10 clear order 2", 2'd2, 5'd17, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0100);
    tick();
    check("R10 clear order 3", 2'd2, 5'd18, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0000);
    tick();
    check("R10 idle after", 2'd0, 5'd0, 1'b0, 8'h0, 8'h0, 1'b0, 4'b0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule